// File: doc/BRIEF.md
# Transmit-Empty Interrupt Generator for a FIFO UART

This block decides when a UART transmitter with a 16-deep character FIFO raises its "holding register empty" interrupt. It watches the FIFO fill level and the CPU strobes, and keeps an empty flag that drives the request. It also returns a 4-bit identification code. The shifter, the FIFO storage and the arbitration between interrupt sources are outside the block.

The empty flag is not always reported at once. If the FIFO held two or more characters at some point since the flag was last set, the flag sets as soon as the level reaches zero. If it never did, the last character is still in the shifter. In that case the flag waits one character time minus the final stop bit. That wait is measured in bit ticks, `frame_bits - 1` of them. A pulse that marks the start of the final stop bit ends the wait early. A change of the FIFO-enable bit skips the wait, so the first interrupt after a mode change comes at once.

Top module: `txe_irq_gen`

## Requirements
- R1: After reset, `thr_empty` is 1, `irq` is 0 and `iir_code` is 4'h1.
- R2: `irq` can be 1 only while both `fifo_en` and `tx_ie` are 1. If either input drops, `irq` is 0 from the next edge.
- R3: `iir_code` is 4'h2 while `irq` is 1. Otherwise it is 4'h1.
- R4: At the first edge that samples `tx_occ` non-zero, `thr_empty` clears.
- R5: Suppose `tx_occ` was 2 or more at some edge after `thr_empty` last set. Then the edge that samples `tx_occ` falling to 0 sets `thr_empty`. If interrupts are enabled, the same edge sets `irq`. Setting `thr_empty` clears the two-byte history.
- R6: In every other case, the fall of `tx_occ` to 0 starts a wait. `thr_empty` and `irq` set at the edge that samples the `(frame_bits-1)`-th `bit_tick` since the fall, or at the edge that samples `stop_mark`, whichever comes first. A refill aborts the wait, and the next fall to 0 starts it from zero.
- R7: `irq` clears at the edge that samples `thr_wr` or `iir_rd`. It stays clear until `thr_empty` rises again.
- R8: If a set condition and a clear strobe are sampled at the same edge, the set wins and `irq` is 1.
- R9: If `fifo_en` changes while `tx_occ` is 0, `thr_empty` sets at once and any running wait is dropped. If the new mode is enabled, `irq` sets at the same edge.
- R10: If `fifo_en && tx_ie` rises while `thr_empty` is 1 and `tx_occ` is 0, `irq` sets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFO mode enable |
| tx_ie | input | 1 | Transmit interrupt enable |
| tx_occ | input | 5 | Transmit FIFO occupancy (0..16) |
| thr_wr | input | 1 | CPU write strobe to the holding register |
| iir_rd | input | 1 | CPU read strobe of the identification register |
| stop_mark | input | 1 | Pulse at the start of the final stop bit |
| bit_tick | input | 1 | One pulse per bit time |
| frame_bits | input | 4 | Bits per frame, including start and stop bits |
| thr_empty | output | 1 | Qualified transmit-empty flag |
| irq | output | 1 | Transmit-empty interrupt request |
| iir_code | output | 4 | Identification code: 4'h2 when pending, 4'h1 when not |

## Verification
Two functions can act at the same edge: a new empty event, which sets the request, and a CPU clear strobe, which clears it. The bench provokes this by driving `iir_rd` in the same cycle in which the occupancy falls from a two-byte fill to zero. It judges the outcome by `irq` remaining 1 afterwards. A second overlap is a mode toggle while a delayed-empty wait is running. The bench checks that the toggle ends the wait at once, and that the request follows the new enable state.

// File: rtl/txe_pkg.sv
package txe_pkg;
    localparam int IIR_W = 4;
    typedef logic [IIR_W-1:0] iir_code_t;

    localparam iir_code_t IIR_NONE     = 4'h1;
    localparam iir_code_t IIR_TX_EMPTY = 4'h2;

    typedef struct packed {
        logic empty;
        logic fifo_en;
        logic enabled;
    } txe_core_t;
endpackage

// File: rtl/txe_fill_track.sv
module txe_fill_track #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] occ,
    input  logic             empty_set,
    output logic             empty_evt,
    output logic             multi
);
    typedef struct packed {
        logic prev_nz;
        logic multi;
    } fill_st_t;

    fill_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.prev_nz = (occ != '0);
        if (empty_set) begin
            st_d.multi = 1'b0;
        end else if (occ >= CNT_W'(2)) begin
            st_d.multi = 1'b1;
        end
    end

    assign empty_evt = st_q.prev_nz && (occ == '0);
    assign multi     = st_q.multi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/txe_delay_timer.sv
module txe_delay_timer #(
    parameter int FB_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            abort,
    input  logic            tick,
    input  logic            stop_mark,
    input  logic [FB_W-1:0] frame_bits,
    output logic            expire
);
    localparam int TW = FB_W + 1;

    typedef struct packed {
        logic          busy;
        logic [TW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t       st_d, st_q;
    logic [TW-1:0] target;
    logic [TW-1:0] cnt_inc;

    always_comb begin
        target  = (frame_bits > FB_W'(1)) ? ({1'b0, frame_bits} - TW'(1)) : TW'(1);
        cnt_inc = st_q.cnt + TW'(1);
        expire  = st_q.busy && !abort &&
                  (stop_mark || (tick && (cnt_inc >= target)));

        st_d = st_q;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end else if (abort || expire) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
        end else if (st_q.busy && tick) begin
            st_d.cnt = cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/txe_pend_latch.sv
module txe_pend_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic enabled,
    input  logic set_req,
    input  logic clr_req,
    output logic pend
);
    logic pend_d, pend_q;

    always_comb begin
        if (!enabled) begin
            pend_d = 1'b0;
        end else if (set_req) begin
            pend_d = 1'b1;
        end else if (clr_req) begin
            pend_d = 1'b0;
        end else begin
            pend_d = pend_q;
        end
    end

    assign pend = pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
        end
    end
endmodule

// File: rtl/txe_irq_gen.sv
module txe_irq_gen
    import txe_pkg::*;
#(
    parameter  int DEPTH = 16,
    parameter  int FB_W  = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             tx_ie,
    input  logic [CNT_W-1:0] tx_occ,
    input  logic             thr_wr,
    input  logic             iir_rd,
    input  logic             stop_mark,
    input  logic             bit_tick,
    input  logic [FB_W-1:0]  frame_bits,
    output logic             thr_empty,
    output logic             irq,
    output logic [3:0]       iir_code
);
    txe_core_t core_d, core_q;

    logic occ_zero;
    logic mode_chg;
    logic empty_evt;
    logic multi_w;
    logic expire;
    logic set_now;
    logic tmr_start;
    logic tmr_abort;
    logic set_req;
    logic clr_req;
    logic pend;

    assign occ_zero  = (tx_occ == '0);
    assign mode_chg  = (fifo_en != core_q.fifo_en);
    assign set_now   = occ_zero && ((empty_evt && multi_w) || mode_chg || expire);
    assign tmr_start = empty_evt && !multi_w && !mode_chg;
    assign tmr_abort = !occ_zero || mode_chg;

    txe_fill_track #(.CNT_W(CNT_W)) fill_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .occ       (tx_occ),
        .empty_set (set_now),
        .empty_evt (empty_evt),
        .multi     (multi_w)
    );

    txe_delay_timer #(.FB_W(FB_W)) tmr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (tmr_start),
        .abort      (tmr_abort),
        .tick       (bit_tick),
        .stop_mark  (stop_mark),
        .frame_bits (frame_bits),
        .expire     (expire)
    );

    always_comb begin
        core_d         = core_q;
        core_d.fifo_en = fifo_en;
        core_d.enabled = fifo_en && tx_ie;
        if (!occ_zero) begin
            core_d.empty = 1'b0;
        end else if (set_now) begin
            core_d.empty = 1'b1;
        end

        set_req = (core_d.empty && !core_q.empty) ||
                  (mode_chg && core_d.empty) ||
                  (core_d.enabled && !core_q.enabled && core_q.empty && occ_zero);
        clr_req = thr_wr || iir_rd;
    end

    txe_pend_latch pend_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .enabled (core_d.enabled),
        .set_req (set_req),
        .clr_req (clr_req),
        .pend    (pend)
    );

    assign thr_empty = core_q.empty;
    assign irq       = pend;
    assign iir_code  = pend ? IIR_TX_EMPTY : IIR_NONE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q.empty   <= 1'b1;
            core_q.fifo_en <= 1'b0;
            core_q.enabled <= 1'b0;
        end else begin
            core_q <= core_d;
        end
    end
endmodule

// File: rtl/txe_irq_gen_chk.sv
module txe_irq_gen_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic             tx_ie,
    input logic [CNT_W-1:0] tx_occ,
    input logic             thr_wr,
    input logic             iir_rd,
    input logic             thr_empty,
    input logic             irq,
    input logic             multi
);
    assert_irq_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(fifo_en && tx_ie));

    assert_fill_clears_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_occ != '0) |=> !thr_empty);

    assert_rise_with_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> thr_empty);

    assert_history_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(thr_empty) |-> !multi);

    assert_fall_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(thr_wr || iir_rd || !(fifo_en && tx_ie)));
endmodule

bind txe_irq_gen txe_irq_gen_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_en   (fifo_en),
    .tx_ie     (tx_ie),
    .tx_occ    (tx_occ),
    .thr_wr    (thr_wr),
    .iir_rd    (iir_rd),
    .thr_empty (thr_empty),
    .irq       (irq),
    .multi     (multi_w)
);

// File: tb/txe_irq_gen_tb_top.sv
module txe_irq_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0;
    logic       tx_ie = 1'b0;
    logic [4:0] tx_occ = '0;
    logic       thr_wr = 1'b0;
    logic       iir_rd = 1'b0;
    logic       stop_mark = 1'b0;
    logic       bit_tick = 1'b0;
    logic [3:0] frame_bits = 4'd10;
    logic       thr_empty;
    logic       irq;
    logic [3:0] iir_code;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    txe_irq_gen dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .tx_ie(tx_ie),
        .tx_occ(tx_occ), .thr_wr(thr_wr), .iir_rd(iir_rd),
        .stop_mark(stop_mark), .bit_tick(bit_tick), .frame_bits(frame_bits),
        .thr_empty(thr_empty), .irq(irq), .iir_code(iir_code)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load_one();
        tx_occ = 5'd1; thr_wr = 1'b1; step(); thr_wr = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 thr_empty", 32'(thr_empty), 1);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 iir_code", 32'(iir_code), 1);

        // R9: enabling FIFO mode while empty gives an immediate interrupt
        fifo_en = 1'b1; tx_ie = 1'b1; step();
        chk("R9 irq after mode on", 32'(irq), 1);
        chk("R3 code pending", 32'(iir_code), 2);

        // R7: an identification read clears the request and it does not re-arm
        iir_rd = 1'b1; step(); iir_rd = 1'b0;
        chk("R7 irq after iir_rd", 32'(irq), 0);
        repeat (5) step();
        chk("R7 no re-arm", 32'(irq), 0);
        chk("R3 code idle", 32'(iir_code), 1);

        // R6: delayed empty, swept over frame lengths
        for (int fb = 2; fb <= 12; fb++) begin
            frame_bits = 4'(fb);
            load_one();
            chk("R4 fill clears empty", 32'(thr_empty), 0);
            chk("R7 write clears irq", 32'(irq), 0);
            tx_occ = 5'd0; step();
            chk("R6 not yet empty", 32'(thr_empty), 0);
            for (int k = 1; k < fb - 1; k++) begin
                bit_tick = 1'b1; step(); bit_tick = 1'b0; step();
                chk("R6 still waiting", 32'(thr_empty), 0);
                chk("R6 no irq while waiting", 32'(irq), 0);
            end
            bit_tick = 1'b1; step(); bit_tick = 1'b0;
            chk("R6 empty after wait", 32'(thr_empty), 1);
            chk("R6 irq after wait", 32'(irq), 1);
        end

        // R6: stop mark ends the wait early
        frame_bits = 4'd10;
        load_one();
        tx_occ = 5'd0; step();
        bit_tick = 1'b1; step(); step(); bit_tick = 1'b0;
        chk("R6 before stop mark", 32'(thr_empty), 0);
        stop_mark = 1'b1; step(); stop_mark = 1'b0;
        chk("R6 stop mark empty", 32'(thr_empty), 1);
        chk("R6 stop mark irq", 32'(irq), 1);

        // R6: refill aborts the wait and the next fall restarts it
        frame_bits = 4'd4;
        load_one();
        tx_occ = 5'd0; step();
        bit_tick = 1'b1; step(); step(); bit_tick = 1'b0;
        chk("R6 two of three ticks", 32'(thr_empty), 0);
        tx_occ = 5'd1; step();
        chk("R4 refill", 32'(thr_empty), 0);
        tx_occ = 5'd0; step();
        bit_tick = 1'b1; step(); step(); bit_tick = 1'b0;
        chk("R6 restarted wait", 32'(thr_empty), 0);
        bit_tick = 1'b1; step(); bit_tick = 1'b0;
        chk("R6 restarted expire", 32'(thr_empty), 1);

        // R5: two-byte history gives an immediate empty, for each peak fill
        for (int pk = 2; pk <= 16; pk++) begin
            load_one();
            tx_occ = 5'(pk); step();
            tx_occ = 5'd1; step();
            chk("R5 draining", 32'(thr_empty), 0);
            tx_occ = 5'd0; step();
            chk("R5 immediate empty", 32'(thr_empty), 1);
            chk("R5 immediate irq", 32'(irq), 1);
        end
        load_one();
        tx_occ = 5'd0; step();
        chk("R5 history cleared", 32'(thr_empty), 0);
        stop_mark = 1'b1; step(); stop_mark = 1'b0;
        chk("R6 stop after history", 32'(thr_empty), 1);

        // R8: set beats a simultaneous clear
        tx_occ = 5'd2; thr_wr = 1'b1; step(); thr_wr = 1'b0;
        chk("R7 cleared before race", 32'(irq), 0);
        tx_occ = 5'd0; iir_rd = 1'b1; step(); iir_rd = 1'b0;
        chk("R8 set wins", 32'(irq), 1);

        // R2 / R10: enable gating and enable rising
        tx_ie = 1'b0; step();
        chk("R2 ie off", 32'(irq), 0);
        tx_occ = 5'd2; step(); tx_occ = 5'd0; step();
        chk("R2 empty without ie", 32'(thr_empty), 1);
        chk("R2 no irq without ie", 32'(irq), 0);
        tx_ie = 1'b1; step();
        chk("R10 ie rise", 32'(irq), 1);

        // R9: mode toggle aborts the delayed wait
        load_one();
        tx_occ = 5'd0; step();
        chk("R6 wait before toggle", 32'(thr_empty), 0);
        fifo_en = 1'b0; step();
        chk("R9 toggle empty", 32'(thr_empty), 1);
        chk("R2 fifo off irq", 32'(irq), 0);
        fifo_en = 1'b1; step();
        chk("R9 toggle on irq", 32'(irq), 1);
        fifo_en = 1'b0; step();
        chk("R2 fifo off clears", 32'(irq), 0);
        chk("R3 code after off", 32'(iir_code), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule